// File: doc/BRIEF.md
# Bus Region Decoder with Programmable Wait Sequencer

This block sits between a processor's 16-bit address bus and three memory-mapped targets: a boot ROM, a serial peripheral and a RAM. The top two address bits select one of the three regions. While the processor's bus-cycle strobe is active, the block pulls the matching active-low chip enable low. The enables are pure combinational logic, so a target sees its select within the same cycle as the address.

The ROM and the serial peripheral are slow. When an access to either region begins, a clocked sequencer raises WAIT for a number of clock cycles, and the processor holds its bus cycle open for that time. Each slow region has its own 3-bit wait count, written through a one-cycle configuration strobe. After reset both counts hold their maximum value of 7, so the system is safe until software lowers them. The count is captured when an access starts. WAIT is raised at most once per strobe period.

Top module: `addr_wait_dec`

## Requirements
- R1: `rom_ce_n` is low exactly when `bus_act` is 1 and address bits [15:14] are 00 (0x0000–0x3FFF).
- R2: `per_ce_n` is low exactly when `bus_act` is 1 and address bits [15:14] are 01 (0x4000–0x7FFF).
- R3: `ram_ce_n` is low exactly when `bus_act` is 1 and address bit 15 is 1 (0x8000–0xFFFF).
- R4: No enable is low while `bus_act` is 0, and at most one enable is low in any cycle.
- R5: After reset, both the ROM count and the peripheral count equal 7, so the first slow access holds `wait_o` high for 7 cycles.
- R6: At the first rising edge where `bus_act` is 1 with a slow region addressed, `wait_o` rises. It then stays high for exactly N cycles, where N is that region's count captured at this edge.
- R7: If a region's count is 0, an access to that region never raises `wait_o`.
- R8: Once `wait_o` falls, it stays low until `bus_act` has returned to 0 and a new access begins.
- R9: An access to the RAM region never raises `wait_o`.
- R10: A clock edge with `cfg_wr`=1 stores `cfg_val` into the ROM count when `cfg_sel`=0, or into the peripheral count when `cfg_sel`=1. A write made during an access does not change the length of the wait already in progress.
- R11: If `bus_act` falls while `wait_o` is high, `wait_o` is low after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Processor address bus |
| bus_act | input | 1 | Bus-cycle strobe, 1 while an access is in progress |
| cfg_wr | input | 1 | Write strobe for a wait count |
| cfg_sel | input | 1 | Count selector: 0 = ROM, 1 = peripheral |
| cfg_val | input | 3 | New wait count |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| per_ce_n | output | 1 | Peripheral chip enable, active low |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| wait_o | output | 1 | Bus cycle stretch request |

## Verification
A configuration write can arrive during a slow access that is already holding WAIT high, so storing a new count and running the current wait can fall in the same cycle. The bench starts a ROM access with a count of 4. In the first wait cycle it writes a count of 1 to the ROM region. It then checks that the current access still gets four WAIT cycles and that the next ROM access gets one. The strobe can also drop while WAIT is still running. The bench cuts a 7-cycle wait after three cycles and checks that WAIT is low after the following edge.

// File: rtl/adw_pkg.sv
package adw_pkg;

    typedef enum logic [1:0] {
        RG_ROM = 2'd0,
        RG_PER = 2'd1,
        RG_RAM = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_HOLD = 2'd1,
        SQ_DONE = 2'd2
    } seq_e;

    // Active-high select bundle used inside the block
    typedef struct packed {
        logic rom;
        logic per;
        logic ram;
    } sel_t;

    // Decode the two most significant address bits into a region
    function automatic region_e region_of(input logic [1:0] top2);
        if (top2[1])
            return RG_RAM;
        else if (top2[0])
            return RG_PER;
        else
            return RG_ROM;
    endfunction

    function automatic logic is_slow(input region_e r);
        return (r != RG_RAM);
    endfunction

endpackage

// File: rtl/adw_decode.sv
module adw_decode
    import adw_pkg::*;
(
    input  logic [1:0] top2,
    input  logic       act,
    output region_e    region,
    output sel_t       sel
);

    always_comb begin
        region  = region_of(top2);
        sel     = '0;
        if (act) begin
            case (region)
                RG_ROM:  sel.rom = 1'b1;
                RG_PER:  sel.per = 1'b1;
                default: sel.ram = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/adw_wait_regs.sv
module adw_wait_regs #(
    parameter int CNT_W  = 3,
    parameter int N_SLOW = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr,
    input  logic [$clog2(N_SLOW)-1:0]     sel,
    input  logic [CNT_W-1:0]              val,
    output logic [N_SLOW-1:0][CNT_W-1:0]  cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar g = 0; g < N_SLOW; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                cnt[g] <= CNT_MAX;
            else if (wr && (int'(sel) == g))
                cnt[g] <= val;
        end
    end

endmodule

// File: rtl/adw_wait_seq.sv
module adw_wait_seq
    import adw_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act,
    input  logic             slow,
    input  logic [CNT_W-1:0] cnt,
    output logic             wait_o
);

    seq_e             state;
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            remain <= '0;
            wait_o <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (act) begin
                        if (slow && (cnt != '0)) begin
                            state  <= SQ_HOLD;
                            remain <= cnt - 1'b1;
                            wait_o <= 1'b1;
                        end else begin
                            state  <= SQ_DONE;
                        end
                    end
                end
                SQ_HOLD: begin
                    if (!act) begin
                        state  <= SQ_IDLE;
                        wait_o <= 1'b0;
                    end else if (remain == '0) begin
                        state  <= SQ_DONE;
                        wait_o <= 1'b0;
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
                default: begin
                    wait_o <= 1'b0;
                    if (!act)
                        state <= SQ_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/addr_wait_dec.sv
module addr_wait_dec
    import adw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bus_act,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [CNT_W-1:0]  cfg_val,
    output logic              rom_ce_n,
    output logic              per_ce_n,
    output logic              ram_ce_n,
    output logic              wait_o
);

    localparam int N_SLOW = 2;

    region_e                     region;
    sel_t                        sel;
    logic [N_SLOW-1:0][CNT_W-1:0] counts;
    logic [CNT_W-1:0]            cur_cnt;

    adw_decode u_dec (
        .top2   (addr[ADDR_W-1 -: 2]),
        .act    (bus_act),
        .region (region),
        .sel    (sel)
    );

    adw_wait_regs #(.CNT_W(CNT_W), .N_SLOW(N_SLOW)) u_regs (
        .clk (clk),
        .rst (rst),
        .wr  (cfg_wr),
        .sel (cfg_sel),
        .val (cfg_val),
        .cnt (counts)
    );

    assign cur_cnt = (region == RG_PER) ? counts[1] : counts[0];

    adw_wait_seq #(.CNT_W(CNT_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .act    (bus_act),
        .slow   (is_slow(region)),
        .cnt    (cur_cnt),
        .wait_o (wait_o)
    );

    assign rom_ce_n = ~sel.rom;
    assign per_ce_n = ~sel.per;
    assign ram_ce_n = ~sel.ram;

endmodule

// File: rtl/addr_wait_dec_chk.sv
module addr_wait_dec_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              bus_act,
    input logic              rom_ce_n,
    input logic              per_ce_n,
    input logic              ram_ce_n,
    input logic              wait_o
);

    localparam int RUN_MAX = (1 << CNT_W) - 1;

    int run_len;

    always_ff @(posedge clk) begin
        if (rst)
            run_len <= 0;
        else if (wait_o)
            run_len <= run_len + 1;
        else
            run_len <= 0;
    end

    // R4
    idle_no_ce_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_act |-> (rom_ce_n && per_ce_n && ram_ce_n));

    // R4
    single_ce_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~rom_ce_n, ~per_ce_n, ~ram_ce_n}));

    // R3
    ram_ce_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_act && addr[ADDR_W-1]) |-> !ram_ce_n);

    // R9
    wait_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wait_o) |-> $past(bus_act && !addr[ADDR_W-1]));

    // R11
    drop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_act |=> !wait_o);

    // R6
    wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_len <= RUN_MAX);

endmodule

bind addr_wait_dec addr_wait_dec_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .bus_act  (bus_act),
    .rom_ce_n (rom_ce_n),
    .per_ce_n (per_ce_n),
    .ram_ce_n (ram_ce_n),
    .wait_o   (wait_o)
);

// File: tb/sim_addr_wait_dec.sv
module sim_addr_wait_dec;

    localparam int CLK_P = 10;
    localparam int NV    = 11;

    // {bus_act, addr[15:0], rom_ce_n, per_ce_n, ram_ce_n}
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 16'h0000, 3'b011},
        {1'b1, 16'h3FFF, 3'b011},
        {1'b1, 16'h2A55, 3'b011},
        {1'b1, 16'h4000, 3'b101},
        {1'b1, 16'h7FFF, 3'b101},
        {1'b1, 16'h8000, 3'b110},
        {1'b1, 16'h9123, 3'b110},
        {1'b1, 16'hFFFF, 3'b110},
        {1'b0, 16'h0000, 3'b111},
        {1'b0, 16'h5000, 3'b111},
        {1'b0, 16'h8000, 3'b111}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        bus_act = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [2:0]  cfg_val = '0;
    logic        rom_ce_n, per_ce_n, ram_ce_n, wait_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    addr_wait_dec u0 (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .bus_act  (bus_act),
        .cfg_wr   (cfg_wr),
        .cfg_sel  (cfg_sel),
        .cfg_val  (cfg_val),
        .rom_ce_n (rom_ce_n),
        .per_ce_n (per_ce_n),
        .ram_ce_n (ram_ce_n),
        .wait_o   (wait_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic write_cnt(input logic s, input logic [2:0] v);
        @(negedge clk);
        cfg_wr  = 1'b1;
        cfg_sel = s;
        cfg_val = v;
        @(negedge clk);
        cfg_wr  = 1'b0;
    endtask

    // Runs one access for 'hold' cycles and returns the number of cycles
    // in which wait_o was seen high. Optionally writes a new ROM count
    // during the first wait cycle.
    task automatic run_access(input logic [15:0] a, input int hold,
                              input logic mid_wr, input logic [2:0] mid_val,
                              output int highs);
        highs = 0;
        @(negedge clk);
        addr    = a;
        bus_act = 1'b1;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (wait_o) highs++;
            if (mid_wr && i == 0) begin
                cfg_wr  = 1'b1;
                cfg_sel = 1'b0;
                cfg_val = mid_val;
            end else begin
                cfg_wr = 1'b0;
            end
        end
        bus_act = 1'b0;
        @(negedge clk);
        check("R11 wait low after strobe drop", int'(wait_o), 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        check("R4 reset enables idle", int'({rom_ce_n, per_ce_n, ram_ce_n}), 7);
        check("R5 reset wait low", int'(wait_o), 0);

        // Decode table
        for (int i = 0; i < NV; i++) begin
            bus_act = VEC[i][19];
            addr    = VEC[i][18:3];
            #1;
            if (!VEC[i][19])
                check("R4 no enable when idle", int'({rom_ce_n, per_ce_n, ram_ce_n}), int'(VEC[i][2:0]));
            else if (VEC[i][18])
                check("R3 RAM region decode", int'({rom_ce_n, per_ce_n, ram_ce_n}), int'(VEC[i][2:0]));
            else if (VEC[i][17])
                check("R2 peripheral region decode", int'({rom_ce_n, per_ce_n, ram_ce_n}), int'(VEC[i][2:0]));
            else
                check("R1 ROM region decode", int'({rom_ce_n, per_ce_n, ram_ce_n}), int'(VEC[i][2:0]));
            @(negedge clk);
        end
        bus_act = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;

        // R5: reset counts are maximum
        run_access(16'h1000, 10, 1'b0, 3'd0, n);
        check("R5 ROM default wait", n, 7);
        run_access(16'h4100, 10, 1'b0, 3'd0, n);
        check("R5 peripheral default wait", n, 7);

        // R6, R8: count 2, long hold, no re-assert
        write_cnt(1'b0, 3'd2);
        run_access(16'h0200, 12, 1'b0, 3'd0, n);
        check("R6 R8 ROM wait 2 no reassert", n, 2);
        run_access(16'h0204, 12, 1'b0, 3'd0, n);
        check("R8 new access waits again", n, 2);

        // R7: zero count
        write_cnt(1'b1, 3'd0);
        run_access(16'h6000, 6, 1'b0, 3'd0, n);
        check("R7 zero count no wait", n, 0);

        // R9: RAM never waits
        run_access(16'hC000, 6, 1'b0, 3'd0, n);
        check("R9 RAM no wait", n, 0);

        // R10: selector routes to the right count
        write_cnt(1'b1, 3'd3);
        run_access(16'h5555, 8, 1'b0, 3'd0, n);
        check("R10 peripheral count 3", n, 3);
        run_access(16'h0001, 8, 1'b0, 3'd0, n);
        check("R10 ROM count kept at 2", n, 2);
        write_cnt(1'b0, 3'd1);
        run_access(16'h3000, 5, 1'b0, 3'd0, n);
        check("R6 ROM count 1", n, 1);

        // R11: strobe drops mid-wait
        write_cnt(1'b0, 3'd7);
        run_access(16'h0010, 3, 1'b0, 3'd0, n);
        check("R11 cut wait length", n, 3);

        // R10: write during an access does not alter ongoing wait
        write_cnt(1'b0, 3'd4);
        run_access(16'h0020, 8, 1'b1, 3'd1, n);
        check("R10 ongoing wait unchanged", n, 4);
        run_access(16'h0030, 8, 1'b0, 3'd0, n);
        check("R10 mid-access write applied next", n, 1);

        finish_run();
    end

endmodule